// File: doc/BRIEF.md
# Triplex Grid Scanner with PWM Dimming

This block drives a three-grid, time-multiplexed fluorescent display from a 63-bit display word and a 10-bit brightness code. It divides its input clock into bit times of four clock cycles. It then steps through three grid slots in a fixed rotation, and each slot lasts 1024 bit times. Within a slot, one grid enable turns on after a short lead-in gap. The 21 segment enables carry that grid's share of the display word for an on-time set by the brightness code.

The brightness code is an on-time measured in bit times. The block caps it at 1016, so a gap always remains before the grid turns off. The display word and the brightness code are sampled once, on the clock edge that starts a slot. A host can rewrite them at any time without tearing the picture. The outputs are registered enables meant to feed external high-voltage drivers.

Top module: `vfd_triplex_scan`

## Requirements
- R1: While reset is held, and for the first 13 clock cycles after it is released, every grid and segment enable is 0. The first grid enable to turn on after reset is grid_o[0], on the 14th clock edge after release. Asserting reset during operation clears all enables by the next clock edge.
- R2: One bit time is 4 clock cycles and one slot is 1024 bit times. The rising edges of any given grid enable are 12288 clock cycles apart.
- R3: At most one grid enable is high at a time. The slots rotate grid_o[0], grid_o[1], grid_o[2], then back to grid_o[0].
- R4: A grid enable is high for 1019 bit times (4076 cycles) per slot. It is off during the first 3 and the last 2 bit times of its slot, so the low gap between one grid's fall and the next grid's rise is 20 cycles.
- R5: In the slot of grid_o[g] (g = 0, 1, 2), seg_o[n] carries disp_word_i[21*g + n] for n = 0..20.
- R6: Segments show data for min(dim_i, 1016) bit times per slot, starting in the same cycle that the grid enable rises. A code of 0 keeps every segment off. Codes 1016 to 1023 all give 1016 bit times.
- R7: No segment enable is high while all grid enables are low.
- R8: The word and the code that are present on the clock edge starting a slot are used for that whole slot. A change made partway through a slot has no effect until the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock (four cycles per bit time) |
| rst_i | input | 1 | Synchronous reset, active high |
| disp_word_i | input | 63 | Display word, three 21-bit slices, one per grid |
| dim_i | input | 10 | Brightness: segment on-time in bit times per slot |
| grid_o | output | 3 | Grid enables, at most one high |
| seg_o | output | 21 | Segment enables for the active grid |

## Verification
The bench sweeps the brightness code across 0, 1, 2, a mid value, 1015, 1016 and codes above the cap. A design with an off-by-one comparison or a missing clamp would report a wrong count of lit cycles in the slot that follows. It measures the grid period, the high width and the inter-grid gap in clock cycles. A wrong prescaler or wrong blanking length would move these by multiples of four. It also changes the word and the code in the middle of a slot. A design that does not hold its inputs for the whole slot would switch segments partway through that slot. Finally, it uses words with a single set bit per slice to expose a mis-indexed slice selection.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    // Counter width for a count of n states; never below one bit.
    function automatic int unsigned cw(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    localparam int unsigned DEF_CLKS_PER_BIT = 4;
    localparam int unsigned DEF_SLOT_BITS    = 1024;
    localparam int unsigned DEF_NUM_GRIDS    = 3;
    localparam int unsigned DEF_SEGS         = 21;
    localparam int unsigned DEF_DIM_W        = 10;
    localparam int unsigned DEF_DIM_MAX      = 1016;
    localparam int unsigned DEF_LEAD_BITS    = 3;
    localparam int unsigned DEF_GRID_BITS    = 1019;

endpackage

// File: rtl/vfd_scan_timebase.sv
module vfd_scan_timebase
    import vfd_scan_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = DEF_CLKS_PER_BIT,
    parameter int unsigned SLOT_BITS    = DEF_SLOT_BITS,
    parameter int unsigned NUM_GRIDS    = DEF_NUM_GRIDS,
    parameter int unsigned BIT_W        = cw(SLOT_BITS),
    parameter int unsigned SLOT_W       = cw(NUM_GRIDS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output logic [BIT_W-1:0]  bit_idx_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic              slot_wrap_o
);

    localparam int unsigned PRE_W = cw(CLKS_PER_BIT);
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(CLKS_PER_BIT - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_GRIDS - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [BIT_W-1:0]  bitc;
        logic [SLOT_W-1:0] slot;
    } pos_t;

    pos_t pos_d, pos_q;
    logic pre_last, bit_last, slot_last;

    always_comb begin
        pre_last  = (pos_q.pre == PRE_LAST);
        bit_last  = (pos_q.bitc == BIT_LAST);
        slot_last = (pos_q.slot == SLOT_LAST);
        pos_d     = pos_q;
        if (pre_last) begin
            pos_d.pre = '0;
            if (bit_last) begin
                pos_d.bitc = '0;
                pos_d.slot = slot_last ? '0 : pos_q.slot + 1'b1;
            end else begin
                pos_d.bitc = pos_q.bitc + 1'b1;
            end
        end else begin
            pos_d.pre = pos_q.pre + 1'b1;
        end
    end

    // Reset parks the scan on the final tick of the last slot, so the
    // first edge after release opens slot 0 and loads its data.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= '{pre: PRE_LAST, bitc: BIT_LAST, slot: SLOT_LAST};
        end else begin
            pos_q <= pos_d;
        end
    end

    assign bit_idx_o   = pos_q.bitc;
    assign slot_idx_o  = pos_q.slot;
    assign slot_wrap_o = pre_last && bit_last;

    // R2: bit counter moves only when the prescaler completes a bit time
    p_bit_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !pre_last |=> $stable(pos_q.bitc));

    p_bit_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (pre_last && !bit_last) |=> (pos_q.bitc == $past(pos_q.bitc) + 1'b1));

    // R3: slots advance in rotation
    p_slot_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        slot_wrap_o |=> (pos_q.slot == (($past(pos_q.slot) == SLOT_LAST) ?
                                        '0 : $past(pos_q.slot) + 1'b1)));

    p_slot_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !slot_wrap_o |=> $stable(pos_q.slot));

endmodule

// File: rtl/vfd_slot_latch.sv
module vfd_slot_latch
    import vfd_scan_pkg::*;
#(
    parameter int unsigned SEGS      = DEF_SEGS,
    parameter int unsigned NUM_GRIDS = DEF_NUM_GRIDS,
    parameter int unsigned DIM_W     = DEF_DIM_W,
    parameter int unsigned DIM_MAX   = DEF_DIM_MAX,
    parameter int unsigned SLOT_W    = cw(NUM_GRIDS),
    parameter int unsigned WORD_W    = SEGS * NUM_GRIDS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [SLOT_W-1:0] slot_idx_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DIM_W-1:0]  dim_i,
    output logic [SEGS-1:0]   slice_o,
    output logic [DIM_W-1:0]  duty_o
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_GRIDS - 1);
    localparam logic [DIM_W-1:0]  DUTY_CAP  = DIM_W'(DIM_MAX);

    typedef struct packed {
        logic [SEGS-1:0]  slice;
        logic [DIM_W-1:0] duty;
    } hold_t;

    hold_t hold_d, hold_q;
    logic [SLOT_W-1:0] next_slot;

    always_comb begin
        next_slot = (slot_idx_i == SLOT_LAST) ? '0 : slot_idx_i + 1'b1;
        hold_d    = hold_q;
        if (load_i) begin
            hold_d.duty = (dim_i >= DUTY_CAP) ? DUTY_CAP : dim_i;
            for (int g = 0; g < NUM_GRIDS; g++) begin
                if (next_slot == SLOT_W'(g)) begin
                    hold_d.slice = word_i[g*SEGS +: SEGS];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign slice_o = hold_q.slice;
    assign duty_o  = hold_q.duty;

    // R6: stored on-time never exceeds the cap
    p_duty_cap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_q.duty <= DUTY_CAP);

    // R8: slot data is frozen between slot starts
    p_hold_midslot_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(hold_q));

endmodule

// File: rtl/vfd_drive_decode.sv
module vfd_drive_decode
    import vfd_scan_pkg::*;
#(
    parameter int unsigned SEGS      = DEF_SEGS,
    parameter int unsigned NUM_GRIDS = DEF_NUM_GRIDS,
    parameter int unsigned DIM_W     = DEF_DIM_W,
    parameter int unsigned LEAD_BITS = DEF_LEAD_BITS,
    parameter int unsigned GRID_BITS = DEF_GRID_BITS,
    parameter int unsigned BIT_W     = cw(DEF_SLOT_BITS),
    parameter int unsigned SLOT_W    = cw(NUM_GRIDS)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [BIT_W-1:0]     bit_idx_i,
    input  logic [SLOT_W-1:0]    slot_idx_i,
    input  logic [SEGS-1:0]      slice_i,
    input  logic [DIM_W-1:0]     duty_i,
    output logic [NUM_GRIDS-1:0] grid_o,
    output logic [SEGS-1:0]      seg_o
);

    localparam int GRID_END = int'(LEAD_BITS + GRID_BITS);

    typedef struct packed {
        logic [NUM_GRIDS-1:0] grid;
        logic [SEGS-1:0]      seg;
    } drive_t;

    drive_t out_d, out_q;
    logic   in_grid, lit;

    always_comb begin
        in_grid = (int'(bit_idx_i) >= int'(LEAD_BITS)) &&
                  (int'(bit_idx_i) < GRID_END);
        lit     = in_grid &&
                  ((int'(bit_idx_i) - int'(LEAD_BITS)) < int'(duty_i));
        out_d.grid = '0;
        for (int g = 0; g < NUM_GRIDS; g++) begin
            out_d.grid[g] = in_grid && (slot_idx_i == SLOT_W'(g));
        end
        out_d.seg = lit ? slice_i : '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign grid_o = out_q.grid;
    assign seg_o  = out_q.seg;

    // R3: never two grids at once
    p_grid_onehot_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(out_q.grid));

    // R7: segments only under a live grid
    p_seg_needs_grid_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (|out_q.seg) |-> (|out_q.grid));

    // R4: lead-in bit times keep every grid dark
    p_lead_blank_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(bit_idx_i) < int'(LEAD_BITS)) |=> (out_q.grid == '0));

endmodule

// File: rtl/vfd_triplex_scan.sv
module vfd_triplex_scan
    import vfd_scan_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = DEF_CLKS_PER_BIT,
    parameter int unsigned SLOT_BITS    = DEF_SLOT_BITS,
    parameter int unsigned NUM_GRIDS    = DEF_NUM_GRIDS,
    parameter int unsigned SEGS         = DEF_SEGS,
    parameter int unsigned DIM_W        = DEF_DIM_W,
    parameter int unsigned DIM_MAX      = DEF_DIM_MAX,
    parameter int unsigned LEAD_BITS    = DEF_LEAD_BITS,
    parameter int unsigned GRID_BITS    = DEF_GRID_BITS
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [NUM_GRIDS*SEGS-1:0] disp_word_i,
    input  logic [DIM_W-1:0]          dim_i,
    output logic [NUM_GRIDS-1:0]      grid_o,
    output logic [SEGS-1:0]           seg_o
);

    localparam int unsigned BIT_W  = cw(SLOT_BITS);
    localparam int unsigned SLOT_W = cw(NUM_GRIDS);
    localparam int unsigned WORD_W = NUM_GRIDS * SEGS;

    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic              slot_wrap;
    logic [SEGS-1:0]   slice;
    logic [DIM_W-1:0]  duty;

    vfd_scan_timebase #(
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .SLOT_BITS    (SLOT_BITS),
        .NUM_GRIDS    (NUM_GRIDS),
        .BIT_W        (BIT_W),
        .SLOT_W       (SLOT_W)
    ) u_timebase (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bit_idx_o   (bit_idx),
        .slot_idx_o  (slot_idx),
        .slot_wrap_o (slot_wrap)
    );

    vfd_slot_latch #(
        .SEGS      (SEGS),
        .NUM_GRIDS (NUM_GRIDS),
        .DIM_W     (DIM_W),
        .DIM_MAX   (DIM_MAX),
        .SLOT_W    (SLOT_W),
        .WORD_W    (WORD_W)
    ) u_latch (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (slot_wrap),
        .slot_idx_i (slot_idx),
        .word_i     (disp_word_i),
        .dim_i      (dim_i),
        .slice_o    (slice),
        .duty_o     (duty)
    );

    vfd_drive_decode #(
        .SEGS      (SEGS),
        .NUM_GRIDS (NUM_GRIDS),
        .DIM_W     (DIM_W),
        .LEAD_BITS (LEAD_BITS),
        .GRID_BITS (GRID_BITS),
        .BIT_W     (BIT_W),
        .SLOT_W    (SLOT_W)
    ) u_decode (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .bit_idx_i  (bit_idx),
        .slot_idx_i (slot_idx),
        .slice_i    (slice),
        .duty_i     (duty),
        .grid_o     (grid_o),
        .seg_o      (seg_o)
    );

endmodule

// File: tb/sim_vfd_triplex_scan.sv
module sim_vfd_triplex_scan;

    localparam int SLOT_CYC = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [62:0] word = '0;
    logic [9:0]  dim = '0;
    logic [2:0]  grid;
    logic [20:0] seg;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vfd_triplex_scan u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .disp_word_i (word),
        .dim_i       (dim),
        .grid_o      (grid),
        .seg_o       (seg)
    );

    typedef struct packed {
        logic [62:0] w;
        logic [9:0]  d;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{w: 63'h7FFF_FFFF_FFFF_FFFF, d: 10'd0},
        '{w: 63'h0000_0400_0020_0001, d: 10'd1},
        '{w: 63'h4000_0200_0010_0000, d: 10'd2},
        '{w: 63'h0123_4567_89AB_CDEF, d: 10'd500},
        '{w: 63'h2AAA_AAAA_AAAA_AAAA, d: 10'd1015},
        '{w: 63'h5555_5555_5555_5555, d: 10'd1016},
        '{w: 63'h1234_5678_9ABC_DEF0, d: 10'd1017},
        '{w: 63'h7FFF_FFFF_FFFF_FFFF, d: 10'd1023}
    };

    function automatic logic [20:0] slice_of(input logic [62:0] w, input int g);
        return w[g*21 +: 21];
    endfunction

    function automatic int grid_idx(input logic [2:0] gv);
        return gv[0] ? 0 : (gv[1] ? 1 : 2);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Returns at the first sample where some grid is high after all were low.
    task automatic wait_rise(output int g);
        logic [2:0] prev;
        prev = grid;
        forever begin
            @(negedge clk);
            if (prev == 3'b000 && grid != 3'b000) break;
            prev = grid;
        end
        g = grid_idx(grid);
    endtask

    // Measures one slot from a grid rise sample (included) for SLOT_CYC samples.
    task automatic measure_slot(input int g, input logic [62:0] w,
                                output int lit, output int gon, output int bad);
        logic [20:0] exp_s;
        exp_s = slice_of(w, g);
        lit = 0; gon = 0; bad = 0;
        for (int i = 0; i < SLOT_CYC; i++) begin
            if (i != 0) @(negedge clk);
            if (grid[g]) gon++;
            if (seg != 21'd0) begin
                if (seg == exp_s && grid[g]) lit++;
                else bad++;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int g, g2, lit, gon, bad, cnt, exp_on;
        logic [2:0] prev;
        bit early_dark;

        // R1: reset state with busy inputs
        word = 63'h7FFF_FFFF_FFFF_FFFF;
        dim  = 10'd1023;
        repeat (5) @(negedge clk);
        check(grid == 3'b000 && seg == 21'd0, "R1", "outputs in reset",
              {grid, seg}, 0);
        rst = 1'b0;
        cnt = 0;
        early_dark = 1'b1;
        forever begin
            @(negedge clk);
            cnt++;
            if (grid != 3'b000) break;
            if (seg != 21'd0) early_dark = 1'b0;
            if (cnt > 100) break;
        end
        check(early_dark, "R1", "segments dark before first grid", 0, 0);
        check(cnt == 14, "R1", "cycle of first grid rise", cnt, 14);
        check(grid == 3'b001, "R1", "first grid after reset", grid, 1);

        // R3 order and R2 period
        wait_rise(g);
        wait_rise(g2);
        check(g2 == (g + 1) % 3, "R3", "grid after", g2, (g + 1) % 3);
        g = g2;
        wait_rise(g2);
        check(g2 == (g + 1) % 3, "R3", "grid after", g2, (g + 1) % 3);
        while (g2 != 0) wait_rise(g2);
        cnt = 0;
        forever begin
            prev = grid;
            @(negedge clk);
            cnt++;
            if (prev == 3'b000 && grid != 3'b000 && grid[0]) break;
            if (cnt > 20000) break;
        end
        check(cnt == 12288, "R2", "grid0 period in cycles", cnt, 12288);

        // R4 high width and gap to next grid
        cnt = 1;
        forever begin
            @(negedge clk);
            if (!grid[0]) break;
            cnt++;
        end
        check(cnt == 4076, "R4", "grid high cycles", cnt, 4076);
        cnt = 1;
        forever begin
            @(negedge clk);
            if (grid != 3'b000) break;
            cnt++;
        end
        check(cnt == 20, "R4", "dark gap between grids", cnt, 20);
        check(grid == 3'b010, "R3", "grid following grid0", grid, 2);

        // Table walk: R5, R6, R7 for each brightness code
        for (int i = 0; i < 8; i++) begin
            wait_rise(g);
            word = VECS[i].w;
            dim  = VECS[i].d;
            wait_rise(g);
            measure_slot(g, VECS[i].w, lit, gon, bad);
            exp_on = 4 * ((int'(VECS[i].d) > 1016) ? 1016 : int'(VECS[i].d));
            check(lit == exp_on, "R6", "lit cycles in slot", lit, exp_on);
            check(bad == 0, "R5", "wrong slice or segment without grid", bad, 0);
            check(gon == 4076, "R4", "grid cycles in slot", gon, 4076);
        end

        // R7: code 0 with full word keeps segments dark across grids
        word = 63'h7FFF_FFFF_FFFF_FFFF;
        dim  = 10'd0;
        wait_rise(g);
        wait_rise(g);
        measure_slot(g, word, lit, gon, bad);
        check(lit == 0 && bad == 0, "R7", "segments lit at zero code", lit + bad, 0);

        // R8: mid-slot change waits for the next slot
        word = 63'h0000_0400_0020_0001;
        dim  = 10'd1016;
        wait_rise(g);
        wait_rise(g);
        lit = 0; bad = 0;
        for (int i = 0; i < SLOT_CYC; i++) begin
            if (i != 0) @(negedge clk);
            if (i == 100) begin
                word = 63'h4000_0200_0010_0000;
                dim  = 10'd0;
            end
            if (seg != 21'd0) begin
                if (seg == slice_of(63'h0000_0400_0020_0001, g)) lit++;
                else bad++;
            end
        end
        check(lit == 4064, "R8", "old data kept for rest of slot", lit, 4064);
        check(bad == 0, "R8", "new word leaked into slot", bad, 0);
        wait_rise(g);
        measure_slot(g, word, lit, gon, bad);
        check(lit + bad == 0, "R8", "new zero code applied next slot", lit + bad, 0);

        // R1: reset during operation
        dim = 10'd1016;
        wait_rise(g);
        wait_rise(g);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(grid == 3'b000 && seg == 21'd0, "R1", "outputs after mid-run reset",
              {grid, seg}, 0);
        rst = 1'b0;

        summary();
        $finish;
    end

endmodule